// File: doc/BRIEF.md
# Signalling Multiframe Aligner for E1 Timeslot 16

This block finds the 16-frame signalling multiframe of an E1 stream. Timeslot 16 of each 2.048 Mb/s frame carries channel-associated signalling bits and the multiframe alignment word. It carries no payload. The aligner sits behind a basic frame aligner. That unit supplies a frame-sync level, a one-cycle strobe per received frame and the timeslot 16 byte of that frame.

While basic frame sync is present and the aligner is not locked, it hunts for the first timeslot 16 byte whose upper four bits are all zero. That frame becomes frame 0. From then on the aligner counts frames 0 to 15 and expects the zero nibble again at every frame 0. Two bad alignment words in a row, or the loss of basic frame sync, put it back into the hunt.

While locked, the aligner reports three things. It gives the frame number and pulses a strobe at each multiframe start. In frames 1 to 15 it also presents the two signalling nibbles of the frame, tagged with the frame number. In frame n the upper nibble holds the A-D bits of channel n and the lower nibble holds those of channel n+15.

Top module: `cas_mf_align`

## Requirements
- R1: While frm_lock_i is low, no strobe starts a hunt: a byte with upper nibble 0000 leaves mf_lock_o at 0, frm_num_o at 0 and mf_stb_o at 0.
- R2: In the hunt, with frm_lock_i high, the first strobe whose byte has bits 7:4 equal to 0000 sets mf_lock_o to 1, frm_num_o to 0 and mf_stb_o to 1 in the cycle after that strobe. A strobe with a non-zero upper nibble leaves the block unlocked.
- R3: While locked, each strobe with frm_lock_i high advances frm_num_o by one, from 15 back to 0, with the new value visible in the cycle after the strobe.
- R4: Between strobes frm_num_o holds its value. A zero upper nibble in frames 1 to 15 does not realign the count.
- R5: While locked, a frame 0 byte whose upper nibble is not 0000 counts as one alignment error. After a single error, mf_lock_o stays 1 and mf_stb_o still pulses.
- R6: A correct alignment word at frame 0 clears the error count, so errors separated by a correct word never drop lock.
- R7: A second consecutive bad alignment word clears mf_lock_o in the cycle after its strobe. It also returns frm_num_o to 0 and gives no mf_stb_o pulse.
- R8: When frm_lock_i goes low while the block is locked, mf_lock_o and frm_num_o are 0 in the next cycle, with no strobe needed.
- R9: While locked, a strobe in frames 1 to 15 gives a one-cycle sig_vld_o pulse in the next cycle. With it, sig_hi_o carries byte bits 7:4 and sig_lo_o carries byte bits 3:0. Frame 0 and unlocked strobes give no pulse.
- R10: mf_stb_o is high for exactly one cycle per multiframe start, and only with mf_lock_o high and frm_num_o equal to 0.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frm_lock_i | input | 1 | Basic frame sync present |
| frm_stb_i | input | 1 | One-cycle strobe per received frame, ts16_i valid |
| ts16_i | input | 8 | Timeslot 16 byte of the strobed frame |
| mf_lock_o | output | 1 | Multiframe sync |
| frm_num_o | output | 4 | Frame number within the multiframe |
| mf_stb_o | output | 1 | One-cycle pulse at frame 0 while locked |
| sig_vld_o | output | 1 | Signalling nibbles valid (frames 1 to 15) |
| sig_hi_o | output | 4 | A-D bits of channel frm_num_o |
| sig_lo_o | output | 4 | A-D bits of channel frm_num_o + 15 |

## Verification
Every frame result (lock, frame number, multiframe strobe, signalling nibbles) is registered once and is due in the single cycle after the clock edge that samples the frame strobe. Loss of basic frame sync takes effect one cycle after the edge that first sees frm_lock_i low. The driver pushes the expected result at the falling edge where it raises the strobe. The monitor pops and compares at the next falling edge, which is one full register stage later. On the falling edge after that, the monitor also confirms that both pulses have dropped again. The two checks for loss of frame sync and for holding between strobes compare the outputs directly, one falling edge after the stimulus.

// File: rtl/cas_mf_pkg.sv
package cas_mf_pkg;

  // Aligner state: hunting for the zero nibble, or holding multiframe lock.
  typedef enum logic {
    MF_HUNT = 1'b0,
    MF_LOCK = 1'b1
  } mf_state_e;

endpackage

// File: rtl/cas_mf_rst_sync.sv
// Reset asserts asynchronously and releases on the clock after two flops.
module cas_mf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/cas_mf_frame_ctr.sv
// Frame position counter within the multiframe, wrapping at FRAMES-1.
module cas_mf_frame_ctr #(
  parameter int FRAMES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      adv,
  output logic [$clog2(FRAMES)-1:0] cnt,
  output logic                      at_last
);

  localparam int FN_W = $clog2(FRAMES);
  localparam logic [FN_W-1:0] LAST = FN_W'(FRAMES - 1);

  logic [FN_W-1:0] cnt_q;
  logic [FN_W-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = clr | adv;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt     = cnt_q;
  assign at_last = (cnt_q == LAST);

endmodule

// File: rtl/cas_mf_err_track.sv
// Counts consecutive bad alignment words; a good word clears the count.
module cas_mf_err_track #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic chk,
  input  logic bad,
  output logic last_strike
);

  localparam int EW = $clog2(LIMIT + 1);
  localparam logic [EW-1:0] LAST_OK = EW'(LIMIT - 1);

  logic [EW-1:0] err_q;
  logic [EW-1:0] err_d;
  logic          err_en;

  always_comb begin
    err_en = clr | chk;
    err_d  = err_q;
    if (clr) begin
      err_d = '0;
    end else if (chk) begin
      err_d = bad ? err_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign last_strike = (err_q == LAST_OK);

endmodule

// File: rtl/cas_mf_sig_tap.sv
// Captures the two signalling nibbles of a locked frame and flags them.
module cas_mf_sig_tap #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NIB_W-1:0] hi_i,
  input  logic [NIB_W-1:0] lo_i,
  output logic [NIB_W-1:0] hi_o,
  output logic [NIB_W-1:0] lo_o,
  output logic             vld_o
);

  logic [NIB_W-1:0] hi_q;
  logic [NIB_W-1:0] lo_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (en) begin
      hi_q <= hi_i;
      lo_q <= lo_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= en;
    end
  end

  assign hi_o  = hi_q;
  assign lo_o  = lo_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/cas_mf_align.sv
module cas_mf_align
  import cas_mf_pkg::*;
#(
  parameter int FRAMES    = 16,
  parameter int NIB_W     = 4,
  parameter int ERR_LIMIT = 2,
  localparam int TS_W     = 2 * NIB_W,
  localparam int FN_W     = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_lock_i,
  input  logic             frm_stb_i,
  input  logic [TS_W-1:0]  ts16_i,
  output logic             mf_lock_o,
  output logic [FN_W-1:0]  frm_num_o,
  output logic             mf_stb_o,
  output logic             sig_vld_o,
  output logic [NIB_W-1:0] sig_hi_o,
  output logic [NIB_W-1:0] sig_lo_o
);

  logic             rst_n_s;
  mf_state_e        state_q;
  mf_state_e        state_d;
  logic             stb_q;
  logic             stb_d;
  logic [NIB_W-1:0] nib_hi;
  logic [NIB_W-1:0] nib_lo;
  logic             hit;
  logic             fstb;
  logic             at_last;
  logic             last_strike;
  logic             mf_check;
  logic             strike_out;
  logic             ctr_clr;
  logic             ctr_adv;
  logic             err_clr;
  logic             sig_en;

  cas_mf_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  assign nib_hi = ts16_i[TS_W-1 -: NIB_W];
  assign nib_lo = ts16_i[NIB_W-1:0];
  assign hit    = (nib_hi == '0);
  assign fstb   = frm_stb_i & frm_lock_i;

  assign mf_check   = (state_q == MF_LOCK) & fstb & at_last;
  assign strike_out = mf_check & ~hit & last_strike;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MF_HUNT: if (fstb && hit) state_d = MF_LOCK;
      MF_LOCK: if (!frm_lock_i || strike_out) state_d = MF_HUNT;
      default: state_d = MF_HUNT;
    endcase
  end

  always_comb begin
    ctr_clr = (state_q == MF_HUNT) | (state_d == MF_HUNT);
    ctr_adv = (state_q == MF_LOCK) & fstb;
    err_clr = (state_d == MF_HUNT);
    sig_en  = (state_q == MF_LOCK) & fstb & ~at_last;
    stb_d   = ((state_q == MF_HUNT) & fstb & hit) | (mf_check & ~strike_out);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= MF_HUNT;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= stb_d;
    end
  end

  cas_mf_frame_ctr #(.FRAMES(FRAMES)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (ctr_clr),
    .adv    (ctr_adv),
    .cnt    (frm_num_o),
    .at_last(at_last)
  );

  cas_mf_err_track #(.LIMIT(ERR_LIMIT)) u_err (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr        (err_clr),
    .chk        (mf_check),
    .bad        (~hit),
    .last_strike(last_strike)
  );

  cas_mf_sig_tap #(.NIB_W(NIB_W)) u_sig (
    .clk  (clk),
    .rst_n(rst_n_s),
    .en   (sig_en),
    .hi_i (nib_hi),
    .lo_i (nib_lo),
    .hi_o (sig_hi_o),
    .lo_o (sig_lo_o),
    .vld_o(sig_vld_o)
  );

  assign mf_lock_o = (state_q == MF_LOCK);
  assign mf_stb_o  = stb_q;

endmodule

// File: rtl/cas_mf_align_chk.sv
module cas_mf_align_chk #(
  parameter int FN_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frm_lock_i,
  input logic            frm_stb_i,
  input logic            mf_lock_o,
  input logic [FN_W-1:0] frm_num_o,
  input logic            mf_stb_o,
  input logic            sig_vld_o
);

  AST_FSYNC_GATES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_lock_i |=> !mf_lock_o);  // R8

  AST_HUNT_NUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_lock_o |-> frm_num_o == '0);  // R1

  AST_NUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mf_lock_o && frm_lock_i && !frm_stb_i |=> $stable(frm_num_o));  // R4

  AST_NUM_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    mf_lock_o && frm_lock_i && frm_stb_i |=>
      (!mf_lock_o || frm_num_o == FN_W'($past(frm_num_o) + 1'b1)));  // R3

  AST_LOCK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_lock_o) |-> (frm_num_o == '0) && mf_stb_o);  // R2

  AST_STB_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    mf_stb_o |-> mf_lock_o && (frm_num_o == '0));  // R10

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mf_stb_o |=> !mf_stb_o);  // R10

  AST_SIG_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    sig_vld_o |-> mf_lock_o && (frm_num_o != '0));  // R9

endmodule

bind cas_mf_align cas_mf_align_chk #(.FN_W(FN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_lock_i(frm_lock_i),
  .frm_stb_i (frm_stb_i),
  .mf_lock_o (mf_lock_o),
  .frm_num_o (frm_num_o),
  .mf_stb_o  (mf_stb_o),
  .sig_vld_o (sig_vld_o)
);

// File: tb/cas_mf_align_test.sv
module cas_mf_align_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic       lock;
    logic [3:0] num;
    logic       stb;
    logic       vld;
    logic [3:0] hi;
    logic [3:0] lo;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       frm_lock_i;
  logic       frm_stb_i;
  logic [7:0] ts16_i;
  logic       mf_lock_o;
  logic [3:0] frm_num_o;
  logic       mf_stb_o;
  logic       sig_vld_o;
  logic [3:0] sig_hi_o;
  logic [3:0] sig_lo_o;

  int compared;
  int mismatched;

  exp_t  exp_q[$];
  string tag_q[$];
  logic  pend;
  logic  post_chk;

  logic       m_lock;
  int         m_num;
  int         m_err;

  cas_mf_align uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_lock_i(frm_lock_i),
    .frm_stb_i (frm_stb_i),
    .ts16_i    (ts16_i),
    .mf_lock_o (mf_lock_o),
    .frm_num_o (frm_num_o),
    .mf_stb_o  (mf_stb_o),
    .sig_vld_o (sig_vld_o),
    .sig_hi_o  (sig_hi_o),
    .sig_lo_o  (sig_lo_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Reference model from the requirements; pushes the result due one cycle later.
  task automatic send_frame(input logic fl, input logic [7:0] b);
    exp_t  e;
    string tag;
    @(negedge clk);
    frm_lock_i = fl;
    ts16_i     = b;
    frm_stb_i  = 1'b1;
    e   = '0;
    tag = "R3";
    if (!fl) begin
      m_lock = 1'b0; m_num = 0; m_err = 0;
      tag = "R1";
    end else if (!m_lock) begin
      tag = "R2";
      if (b[7:4] == 4'h0) begin
        m_lock = 1'b1; m_num = 0; m_err = 0;
        e.stb = 1'b1;
      end
    end else begin
      m_num = (m_num + 1) % 16;
      if (m_num == 0) begin
        if (b[7:4] == 4'h0) begin
          m_err = 0; e.stb = 1'b1; tag = "R6";
        end else begin
          m_err++;
          if (m_err == 2) begin
            m_lock = 1'b0; m_num = 0; m_err = 0; tag = "R7";
          end else begin
            e.stb = 1'b1; tag = "R5";
          end
        end
      end else begin
        e.vld = 1'b1; e.hi = b[7:4]; e.lo = b[3:0]; tag = "R9";
      end
    end
    e.lock = m_lock;
    e.num  = 4'(m_num);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    frm_stb_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sig_frames();
    for (int i = 1; i < 16; i++) begin
      if (i == 5) send_frame(1'b1, 8'h03);  // zero upper nibble mid-multiframe (R4)
      else send_frame(1'b1, {4'(i), 4'(~i)});
    end
  endtask

  // Monitor: pops the expected item one cycle after each sampled strobe.
  always @(posedge clk) pend <= rst_n && frm_stb_i;

  initial begin
    post_chk = 1'b0;
    forever begin
      @(negedge clk);
      if (pend) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "mf_lock_o", int'(mf_lock_o), int'(e.lock));
        check(t, "frm_num_o", int'(frm_num_o), int'(e.num));
        check(t, "mf_stb_o", int'(mf_stb_o), int'(e.stb));
        check(t, "sig_vld_o", int'(sig_vld_o), int'(e.vld));
        if (e.vld) begin
          check(t, "sig_hi_o", int'(sig_hi_o), int'(e.hi));
          check(t, "sig_lo_o", int'(sig_lo_o), int'(e.lo));
        end
        post_chk = e.stb | e.vld;
      end else if (post_chk) begin
        check("R10", "mf_stb_o after pulse", int'(mf_stb_o), 0);
        check("R9", "sig_vld_o after pulse", int'(sig_vld_o), 0);
        post_chk = 1'b0;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    compared = 0; mismatched = 0;
    m_lock = 1'b0; m_num = 0; m_err = 0;
    rst_n = 1'b0; frm_lock_i = 1'b0; frm_stb_i = 1'b0; ts16_i = '0;
    pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "mf_lock_o", int'(mf_lock_o), 0);
    check("R11", "frm_num_o", int'(frm_num_o), 0);
    check("R11", "mf_stb_o", int'(mf_stb_o), 0);
    check("R11", "sig_vld_o", int'(sig_vld_o), 0);

    send_frame(1'b0, 8'h00);       // R1: no hunt without frame sync
    send_frame(1'b0, 8'h0F);
    send_frame(1'b1, 8'hA5);       // R2: non-zero nibble, stay in hunt
    send_frame(1'b1, 8'h10);
    send_frame(1'b1, 8'h0C);       // R2: lock, frame 0
    sig_frames();
    check("R4", "frm_num_o between strobes", int'(frm_num_o), 15);
    send_frame(1'b1, 8'h0E);       // R3: wrap to 0, good word
    sig_frames();
    send_frame(1'b1, 8'h9E);       // R5: first error, lock kept
    sig_frames();
    send_frame(1'b1, 8'h0B);       // R6: good word clears count
    sig_frames();
    send_frame(1'b1, 8'h4B);       // R5: one error again
    sig_frames();
    send_frame(1'b1, 8'hF1);       // R7: second consecutive error drops lock
    send_frame(1'b1, 8'h22);       // hunt continues
    send_frame(1'b1, 8'h01);       // relock
    send_frame(1'b1, 8'h7E);
    send_frame(1'b1, 8'h3C);

    @(negedge clk);                // R8: frame sync lost with no strobe
    frm_lock_i = 1'b0;
    @(negedge clk);
    check("R8", "mf_lock_o", int'(mf_lock_o), 0);
    check("R8", "frm_num_o", int'(frm_num_o), 0);
    m_lock = 1'b0; m_num = 0; m_err = 0;
    send_frame(1'b0, 8'h00);       // R1 again after loss
    send_frame(1'b1, 8'h05);       // relock after regain

    repeat (4) @(negedge clk);
    check("R10", "queue drained", exp_q.size(), 0);
    summary();
  end

endmodule